// File: doc/BRIEF.md
# Four-Bank Scratchpad Arbiter

This block is the local scratchpad of one processing tile: 32 KB of plain SRAM, with no tags, no caching and no coherency logic. The storage is split into four banks, each one 64 bits wide. Four requesters share it: instruction fetch, the core's load/store path, the DMA engine and accesses that arrive from the on-chip mesh. Each request is steered to a bank by its address. Requests that land on different banks are all granted in the same cycle. When two or more requests hit the same bank, one is granted and the others are stalled until a later cycle.

Every access is either a 32-bit word, which uses one half of the 64-bit bank word, or a 64-bit double that moves two consecutive 32-bit words in one access. Writes carry byte enables, so the bytes that are not enabled keep their old contents. The address space is a flat 32 bits with no protection check. Address bits above the row field are ignored inside the tile. Read data comes back one cycle after the grant, on the return lane of the requester that was granted.

Top module: `lmem_bank_arb`

## Requirements
- R1: The bank is address bits [4:3] and the row is the next log2(ROWS) bits starting at bit 5 (bits [14:5] for 1024 rows). All higher address bits and bits [1:0] are ignored, so addresses that differ only in those bits reach the same storage.
- R2: Requests that target four different banks are all granted in the same cycle, with no stall.
- R3: At most one requester is granted per bank per cycle. When none of the contenders was stalled in the previous cycle, the winner is chosen by fixed priority: index 3 (mesh), then 2 (DMA), then 1 (load/store), then 0 (fetch).
- R4: A requester that was stalled in the previous cycle beats every contender that was not stalled. Among several such waiting requesters, the fixed order of R3 decides.
- R5: stall_o[i] is high exactly when req_i[i] is high and gnt_o[i] is low. No grant is given without a request.
- R6: A granted read raises rvalid_o[i] in the next cycle, with the data on lane i of rdata_o. A granted write and a cycle without a grant leave rvalid_o[i] low.
- R7: A 32-bit access (dbl_i[i]=0) uses the bank-word half selected by address bit 2 (1 selects bits 63:32). A read returns that half in bits 31:0 of the lane, with bits 63:32 zero. A write uses be bits 3:0 and wdata bits 31:0 on that half only, and the other half is left unchanged.
- R8: A 64-bit access (dbl_i[i]=1) reads or writes the whole bank word, with be bits 7:0 mapped to bytes 7:0. Address bit 2 is ignored.
- R9: A byte whose enable is 0 keeps its previous value. A write with all enables 0 changes nothing.
- R10: While rst_ni is low, and for two clock edges after it rises, no request is granted and rvalid_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released through an internal two-stage synchroniser |
| req_i | input | 4 | Request per requester (0 fetch, 1 load/store, 2 DMA, 3 mesh) |
| we_i | input | 4 | Write (1) or read (0) per requester |
| dbl_i | input | 4 | 64-bit access (1) or 32-bit access (0) per requester |
| addr_i | input | 4*ADDR_W | Byte address per requester; lane i is bits i*ADDR_W +: ADDR_W |
| be_i | input | 32 | Byte enables per requester, 8 bits per lane |
| wdata_i | input | 256 | Write data per requester, 64 bits per lane |
| gnt_o | output | 4 | Request accepted in this cycle |
| stall_o | output | 4 | Request held back by a bank conflict or by reset |
| rvalid_o | output | 4 | Read data valid on the lane, one cycle after the grant |
| rdata_o | output | 256 | Read data per requester, 64 bits per lane |

## Verification
The bench builds the block with ROWS=16, which gives a 4-bit row field at bits [8:5] and a total of 64 bank words. With that size the whole memory can be written before any read, random traffic keeps returning to rows it has already written, and address bits from 9 upward can be made to alias. ADDR_W stays at 32, so the ignored upper bits cover a wide span. The bench drives directed patterns for reset, distinct-bank grants, fixed-priority and waited-requester conflicts, half-word and byte-enable writes, and then applies a long run of random traffic that is compared cycle by cycle against a behavioural model of bank arbitration and memory content.

// File: rtl/lmem_pkg.sv
package lmem_pkg;
  localparam int NREQ     = 4;   // fetch, load/store, DMA, mesh
  localparam int NBANK    = 4;
  localparam int BANK_W   = $clog2(NBANK);
  localparam int DATA_W   = 64;
  localparam int HALF_W   = DATA_W / 2;
  localparam int BE_W     = DATA_W / 8;
  localparam int HALF_BE  = BE_W / 2;
  localparam int HALF_BIT = 2;             // selects 32-bit half
  localparam int BANK_LSB = 3;
  localparam int ROW_LSB  = BANK_LSB + BANK_W;

  typedef enum logic [1:0] {
    RQ_FETCH = 2'd0,
    RQ_LDST  = 2'd1,
    RQ_DMA   = 2'd2,
    RQ_MESH  = 2'd3
  } req_id_e;
endpackage

// File: rtl/lmem_req_decode.sv
module lmem_req_decode import lmem_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int ROW_W  = 10
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              dbl_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic              hi_o,
  output logic [BE_W-1:0]   be_o,
  output logic [DATA_W-1:0] wdata_o
);
  // R1: bank and row fields; upper bits are aliased away
  assign bank_o = addr_i[BANK_LSB +: BANK_W];
  assign row_o  = addr_i[ROW_LSB +: ROW_W];
  assign hi_o   = addr_i[HALF_BIT];

  logic unused_addr;
  assign unused_addr = ^{addr_i[ADDR_W-1:ROW_LSB+ROW_W], addr_i[1:0]};

  // R7 / R8: steer byte enables and replicate the word for 32-bit writes
  always_comb begin
    if (dbl_i) begin
      be_o    = be_i;
      wdata_o = wdata_i;
    end else begin
      be_o    = hi_o ? {be_i[HALF_BE-1:0], {HALF_BE{1'b0}}}
                     : {{HALF_BE{1'b0}}, be_i[HALF_BE-1:0]};
      wdata_o = {wdata_i[HALF_W-1:0], wdata_i[HALF_W-1:0]};
    end
  end
endmodule

// File: rtl/lmem_bank_pick.sv
module lmem_bank_pick import lmem_pkg::*; (
  input  logic [NREQ-1:0] hit_i,     // requesters aimed at this bank
  input  logic [NREQ-1:0] waited_i,  // stalled in the previous cycle
  output logic [NREQ-1:0] win_o
);
  logic [NREQ-1:0] aged;
  logic [NREQ-1:0] cand;

  // R4: waiting contenders shadow fresh ones
  assign aged = hit_i & waited_i;
  assign cand = (|aged) ? aged : hit_i;

  // R3: highest index wins among the candidates
  always_comb begin
    win_o = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (cand[i]) begin
        win_o    = '0;
        win_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lmem_bank_sram.sv
module lmem_bank_sram import lmem_pkg::*; #(
  parameter int ROWS = 1024,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [ROWS];
  logic [DATA_W-1:0] rd_q;

  // R9: byte-masked write; registered read
  always_ff @(posedge clk) begin
    if (en_i && we_i) begin
      for (int k = 0; k < BE_W; k++) begin
        if (be_i[k]) mem_q[row_i][k*8 +: 8] <= wdata_i[k*8 +: 8];
      end
    end
    if (en_i && !we_i) rd_q <= mem_q[row_i];
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/lmem_bank_arb.sv
module lmem_bank_arb import lmem_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int ROWS   = 1024
) (
  input  logic                   clk,
  input  logic                   rst_ni,
  input  logic [NREQ-1:0]        req_i,
  input  logic [NREQ-1:0]        we_i,
  input  logic [NREQ-1:0]        dbl_i,
  input  logic [NREQ*ADDR_W-1:0] addr_i,
  input  logic [NREQ*BE_W-1:0]   be_i,
  input  logic [NREQ*DATA_W-1:0] wdata_i,
  output logic [NREQ-1:0]        gnt_o,
  output logic [NREQ-1:0]        stall_o,
  output logic [NREQ-1:0]        rvalid_o,
  output logic [NREQ*DATA_W-1:0] rdata_o
);
  localparam int ROW_W = $clog2(ROWS);

  // R10: reset release synchroniser
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // Per-requester decode
  logic [BANK_W-1:0] bank_r [NREQ];
  logic [ROW_W-1:0]  row_r  [NREQ];
  logic [BE_W-1:0]   be_r   [NREQ];
  logic [DATA_W-1:0] wd_r   [NREQ];
  logic [NREQ-1:0]   hi_r;

  for (genvar i = 0; i < NREQ; i++) begin : g_dec
    lmem_req_decode #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) dec_i (
      .addr_i  (addr_i[i*ADDR_W +: ADDR_W]),
      .dbl_i   (dbl_i[i]),
      .be_i    (be_i[i*BE_W +: BE_W]),
      .wdata_i (wdata_i[i*DATA_W +: DATA_W]),
      .bank_o  (bank_r[i]),
      .row_o   (row_r[i]),
      .hi_o    (hi_r[i]),
      .be_o    (be_r[i]),
      .wdata_o (wd_r[i])
    );
  end

  // Per-bank hit matrix
  logic [NREQ-1:0] hit_b [NBANK];
  logic [NREQ-1:0] win_b [NBANK];
  logic [NREQ-1:0] waited_q, waited_d;

  always_comb begin
    for (int b = 0; b < NBANK; b++) begin
      for (int i = 0; i < NREQ; i++) begin
        hit_b[b][i] = req_i[i] & rst_sync_n & (bank_r[i] == BANK_W'(b));
      end
    end
  end

  logic [DATA_W-1:0] bank_rd [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic              bk_en, bk_we;
    logic [ROW_W-1:0]  bk_row;
    logic [BE_W-1:0]   bk_be;
    logic [DATA_W-1:0] bk_wd;

    lmem_bank_pick pick_i (
      .hit_i    (hit_b[b]),
      .waited_i (waited_q),
      .win_o    (win_b[b])
    );

    always_comb begin
      bk_en  = |win_b[b];
      bk_we  = 1'b0;
      bk_row = '0;
      bk_be  = '0;
      bk_wd  = '0;
      for (int i = 0; i < NREQ; i++) begin
        if (win_b[b][i]) begin
          bk_we  = we_i[i];
          bk_row = row_r[i];
          bk_be  = be_r[i];
          bk_wd  = wd_r[i];
        end
      end
    end

    lmem_bank_sram #(.ROWS(ROWS)) sram_i (
      .clk     (clk),
      .en_i    (bk_en),
      .we_i    (bk_we),
      .row_i   (bk_row),
      .be_i    (bk_be),
      .wdata_i (bk_wd),
      .rdata_o (bank_rd[b])
    );
  end

  // R2 / R5: gather grants and stalls
  logic [NREQ-1:0] gnt;
  always_comb begin
    gnt = '0;
    for (int b = 0; b < NBANK; b++) gnt = gnt | win_b[b];
  end
  assign gnt_o   = gnt;
  assign stall_o = req_i & ~gnt;

  // R4: remember who lost this cycle
  always_comb waited_d = req_i & ~gnt;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)          waited_q <= '0;
    else if (!rst_sync_n) waited_q <= '0;
    else                  waited_q <= waited_d;
  end

  // R6: return routing, one cycle after the grant
  logic [NREQ-1:0]   rvld_q, rvld_d;
  logic [BANK_W-1:0] rbank_q [NREQ];
  logic [BANK_W-1:0] rbank_d [NREQ];
  logic [NREQ-1:0]   rhi_q, rhi_d, rdbl_q, rdbl_d;

  always_comb begin
    rvld_d = gnt & ~we_i;
    rhi_d  = rhi_q;
    rdbl_d = rdbl_q;
    for (int i = 0; i < NREQ; i++) begin
      rbank_d[i] = rbank_q[i];
      if (rvld_d[i]) begin
        rbank_d[i] = bank_r[i];
        rhi_d[i]   = hi_r[i];
        rdbl_d[i]  = dbl_i[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rvld_q <= '0;
      rhi_q  <= '0;
      rdbl_q <= '0;
      for (int i = 0; i < NREQ; i++) rbank_q[i] <= '0;
    end else begin
      rvld_q <= rvld_d;
      rhi_q  <= rhi_d;
      rdbl_q <= rdbl_d;
      for (int i = 0; i < NREQ; i++) rbank_q[i] <= rbank_d[i];
    end
  end

  // R7 / R8: lane formatting
  always_comb begin
    logic [DATA_W-1:0] word;
    for (int i = 0; i < NREQ; i++) begin
      word = bank_rd[rbank_q[i]];
      if (rdbl_q[i])
        rdata_o[i*DATA_W +: DATA_W] = word;
      else
        rdata_o[i*DATA_W +: DATA_W] = {{HALF_W{1'b0}},
                                       rhi_q[i] ? word[DATA_W-1:HALF_W] : word[HALF_W-1:0]};
    end
  end
  assign rvalid_o = rvld_q;
endmodule

// File: rtl/lmem_bank_arb_chk.sv
module lmem_bank_arb_chk import lmem_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input logic                   clk,
  input logic                   rst_ni,
  input logic [NREQ-1:0]        req_i,
  input logic [NREQ-1:0]        we_i,
  input logic [NREQ*ADDR_W-1:0] addr_i,
  input logic [NREQ-1:0]        gnt_o,
  input logic [NREQ-1:0]        stall_o,
  input logic [NREQ-1:0]        rvalid_o
);
  function automatic logic [BANK_W-1:0] bk(input int i);
    return addr_i[i*ADDR_W + BANK_LSB +: BANK_W];
  endfunction

  logic [NREQ-1:0] alone, beaten;
  always_comb begin
    for (int i = 0; i < NREQ; i++) begin
      alone[i]  = 1'b1;
      beaten[i] = 1'b0;
      for (int j = 0; j < NREQ; j++) begin
        if (j != i && req_i[j] && bk(j) == bk(i)) alone[i] = 1'b0;
        if (j != i && gnt_o[j] && bk(j) == bk(i)) beaten[i] = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NREQ; i++) begin : g_one
    // R5
    gnt_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_ni)
      gnt_o[i] |-> req_i[i]);
    // R2
    lone_grant_chk: assert property (@(posedge clk) disable iff (!rst_ni)
      (req_i[i] && alone[i]) |-> gnt_o[i]);
    // R3
    stall_has_winner_chk: assert property (@(posedge clk) disable iff (!rst_ni)
      stall_o[i] |-> beaten[i]);
    // R6
    rvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_ni)
      (gnt_o[i] && !we_i[i]) |=> rvalid_o[i]);
    // R6
    rvalid_only_read_chk: assert property (@(posedge clk) disable iff (!rst_ni)
      !(gnt_o[i] && !we_i[i]) |=> !rvalid_o[i]);
    for (genvar j = i + 1; j < NREQ; j++) begin : g_pair
      // R3
      bank_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (gnt_o[i] && gnt_o[j]) |-> (bk(i) != bk(j)));
    end
  end
endmodule

bind lmem_bank_arb lmem_bank_arb_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rst_ni   (rst_sync_n),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .gnt_o    (gnt_o),
  .stall_o  (stall_o),
  .rvalid_o (rvalid_o)
);

// File: tb/lmem_bank_arb_tb.sv
module lmem_bank_arb_tb_top;
  localparam int AW = 32;
  localparam int RW = 16;   // rows per bank in this build

  logic         clk = 1'b0;
  logic         rst_ni;
  logic [3:0]   req, we, dbl;
  logic [127:0] addr;
  logic [31:0]  be;
  logic [255:0] wdata;
  logic [3:0]   gnt, stall, rvalid;
  logic [255:0] rdata;

  lmem_bank_arb #(.ADDR_W(AW), .ROWS(RW)) dut_i (
    .clk(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .dbl_i(dbl),
    .addr_i(addr), .be_i(be), .wdata_i(wdata), .gnt_o(gnt),
    .stall_o(stall), .rvalid_o(rvalid), .rdata_o(rdata));

  always #5 clk = ~clk;

  int     errors = 0;
  int     checks = 0;
  bit     done   = 0;
  string  cur_req = "R10";

  // Reference model state
  logic [63:0] mem_m [4*RW];
  logic [3:0]  waited_m = '0;
  int          rs_m = 0;
  logic [3:0]  exp_rv = '0;
  logic [63:0] exp_rd [4];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int bank_of(input int i);
    return int'(addr[i*32+3 +: 2]);
  endfunction
  function automatic int row_of(input int i);
    return int'(addr[i*32+5 +: 4]);
  endfunction

  task automatic clr();
    req = '0; we = '0; dbl = '0; addr = '0; be = '0; wdata = '0;
  endtask

  task automatic put(input int i, input bit w, input bit d, input logic [31:0] a,
                     input logic [7:0] b, input logic [63:0] wd);
    req[i] = 1'b1; we[i] = w; dbl[i] = d;
    addr[i*32 +: 32] = a; be[i*8 +: 8] = b; wdata[i*64 +: 64] = wd;
  endtask

  // One cycle: inputs already set after a falling edge
  task automatic step();
    logic [3:0] eg;
    #1;
    eg = '0;
    if (rs_m >= 2) begin
      for (int b = 0; b < 4; b++) begin
        bit anyw = 0;
        bit got  = 0;
        for (int i = 0; i < 4; i++)
          if (req[i] && bank_of(i) == b && waited_m[i]) anyw = 1;
        for (int i = 3; i >= 0; i--) begin
          if (!got && req[i] && bank_of(i) == b && (!anyw || waited_m[i])) begin
            eg[i] = 1'b1; got = 1;
          end
        end
      end
    end
    chk(gnt == eg, cur_req, "gnt", 64'(gnt), 64'(eg));
    chk(stall == (req & ~eg), "R5", "stall", 64'(stall), 64'(req & ~eg));
    for (int i = 0; i < 4; i++) begin
      chk(rvalid[i] == exp_rv[i], "R6", $sformatf("rvalid[%0d]", i),
          64'(rvalid[i]), 64'(exp_rv[i]));
      if (exp_rv[i])
        chk(rdata[i*64 +: 64] == exp_rd[i], cur_req, $sformatf("rdata[%0d]", i),
            rdata[i*64 +: 64], exp_rd[i]);
    end
    // next-cycle return and memory update
    for (int i = 0; i < 4; i++) begin
      int idx = bank_of(i) * RW + row_of(i);
      bit hi  = addr[i*32+2];
      exp_rv[i] = eg[i] & ~we[i];
      if (eg[i] && !we[i])
        exp_rd[i] = dbl[i] ? mem_m[idx]
                           : {32'h0, hi ? mem_m[idx][63:32] : mem_m[idx][31:0]};
      if (eg[i] && we[i]) begin
        for (int k = 0; k < 8; k++) begin
          if (dbl[i]) begin
            if (be[i*8+k]) mem_m[idx][k*8 +: 8] = wdata[i*64 + k*8 +: 8];
          end else if (k < 4 && be[i*8+k]) begin
            mem_m[idx][(hi ? 32 : 0) + k*8 +: 8] = wdata[i*64 + k*8 +: 8];
          end
        end
      end
    end
    waited_m = (rs_m >= 2) ? (req & ~eg) : 4'b0;
    @(posedge clk);
    if (!rst_ni) rs_m = 0; else if (rs_m < 2) rs_m++;
    @(negedge clk);
  endtask

  function automatic logic [31:0] mk(input int bank, input int row, input bit hi);
    return 32'((row << 5) | (bank << 3) | (int'(hi) << 2));
  endfunction

  initial begin
    rst_ni = 1'b1;
    clr();
    #1 rst_ni = 1'b0;
    @(negedge clk);

    // R10: requests during reset and the two edges after release
    cur_req = "R10";
    for (int i = 0; i < 4; i++) put(i, 0, 1, mk(i, 0, 0), 8'hFF, 64'h0);
    step(); step();
    rst_ni = 1'b1;
    step(); step();
    clr();
    step();

    // R8: fill every word with a double write from the mesh port
    cur_req = "R8";
    for (int b = 0; b < 4; b++)
      for (int r = 0; r < RW; r++) begin
        clr(); put(3, 1, 1, mk(b, r, 0), 8'hFF, {16'hA5A5, 8'(b), 8'(r), 32'h1234_0000 + 32'(r)});
        step();
      end
    clr();

    // R2: four banks in parallel
    cur_req = "R2";
    put(0, 0, 1, mk(0, 1, 0), 0, 0); put(1, 0, 1, mk(1, 2, 0), 0, 0);
    put(2, 0, 1, mk(2, 3, 0), 0, 0); put(3, 0, 1, mk(3, 4, 0), 0, 0);
    step(); clr(); step();

    // R3: fixed priority with fresh contenders
    cur_req = "R3";
    for (int i = 0; i < 4; i++) put(i, 0, 1, mk(1, 5 + i, 0), 0, 0);
    step(); clr(); step();
    put(0, 0, 1, mk(2, 1, 0), 0, 0); put(1, 0, 1, mk(2, 2, 0), 0, 0);
    put(2, 0, 1, mk(2, 3, 0), 0, 0);
    step(); clr(); step();
    put(0, 0, 1, mk(3, 1, 0), 0, 0); put(1, 0, 1, mk(3, 2, 0), 0, 0);
    step(); clr(); step();

    // R4: waited requester takes the bank on a repeated conflict
    cur_req = "R4";
    put(0, 0, 1, mk(0, 7, 0), 0, 0); put(3, 0, 1, mk(0, 8, 0), 0, 0);
    repeat (4) step();
    clr(); step();
    put(0, 0, 1, mk(1, 7, 0), 0, 0); put(1, 0, 1, mk(1, 8, 0), 0, 0);
    put(2, 0, 1, mk(1, 9, 0), 0, 0);
    repeat (4) step();
    clr(); step();

    // R7: 32-bit writes to the high half, then read both halves and the whole word
    cur_req = "R7";
    put(1, 1, 0, mk(2, 6, 1), 8'hF5, 64'hFFFF_FFFF_DEAD_BEEF); step(); clr();
    put(1, 0, 0, mk(2, 6, 1), 0, 0); step(); clr();
    put(1, 0, 0, mk(2, 6, 0), 0, 0); step(); clr();
    put(2, 0, 1, mk(2, 6, 0), 0, 0); step(); clr();
    put(0, 1, 0, mk(3, 6, 0), 8'h0F, 64'h0000_0000_CAFE_F00D); step(); clr();
    put(0, 0, 1, mk(3, 6, 1), 0, 0); step(); clr(); step();

    // R9: all enables off changes nothing
    cur_req = "R9";
    put(2, 1, 1, mk(0, 9, 0), 8'h00, 64'hFFFF_FFFF_FFFF_FFFF); step(); clr();
    put(2, 1, 1, mk(0, 10, 0), 8'h81, 64'h1100_0000_0000_0022); step(); clr();
    put(2, 0, 1, mk(0, 9, 0), 0, 0); put(3, 0, 1, mk(1, 10, 0), 0, 0); step(); clr();
    put(2, 0, 1, mk(0, 10, 0), 0, 0); step(); clr(); step();

    // R1: upper address bits alias to the same word
    cur_req = "R1";
    put(3, 1, 1, 32'hFFFF_FE00 | mk(1, 11, 0) | 32'h3, 8'hFF, 64'h0123_4567_89AB_CDEF);
    step(); clr();
    put(0, 0, 1, mk(1, 11, 0), 0, 0); step(); clr();
    put(1, 0, 0, 32'h8000_0000 | mk(1, 11, 1), 0, 0); step(); clr(); step();

    // R6: mixed reads and writes on separate banks
    cur_req = "R6";
    put(0, 1, 1, mk(0, 12, 0), 8'hFF, 64'h5555_6666_7777_8888);
    put(1, 0, 1, mk(1, 12, 0), 0, 0);
    put(2, 1, 0, mk(2, 12, 1), 8'h0F, 64'h9999_AAAA);
    put(3, 0, 0, mk(3, 12, 1), 0, 0);
    step(); clr(); step();

    // R4: random traffic against the model
    cur_req = "R4";
    for (int n = 0; n < 600; n++) begin
      clr();
      for (int i = 0; i < 4; i++) begin
        if ($urandom_range(0, 3) != 0) begin
          logic [31:0] a;
          a = $urandom();
          put(i, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a,
              8'($urandom()), {$urandom(), $urandom()});
        end
      end
      step();
    end
    clr(); step();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule